// File: doc/BRIEF.md
# Learned Prefetcher Selection Engine

This block chooses which of four prefetchers should serve the memory stream. It keeps a small table of learned scores, one for each pairing of an access-pattern state with a candidate prefetcher. Each time the last-level cache reports a miss, the engine reads the scores in the row of the earlier state and picks the best candidate. It then refines the score of the pair it chose last time using a temporal-difference rule. The rule blends the old score with a target built from a reward and the discounted best score of the current state.

The reward comes from how well the DRAM cache is doing. Hit and miss pulses from that cache are tallied over fixed windows of 256 accesses. The hit-minus-miss balance of the last finished window is the reward used by later updates. Each selection and update takes a short fixed sequence of cycles. A last-level-cache miss that arrives during that sequence is discarded, and a counter records it.

Top module: `qsel_engine`

## Requirements
- R1: After reset, act_out is 0, act_valid and busy are 0, drop_cnt is 0, every stored score is 0, the reward is 0 and the DRAM-cache window is empty.
- R2: Only a last-level-cache miss accepted while busy is 0 starts work. In all other cycles the score table, act_out and the previous-action register keep their values.
- R3: The selected action is the index of the largest score in the row of the st_prev value captured at acceptance, read before this request's update. A tie goes to the lowest index. The codes are 0 = no prefetch, 1 = next-line, 2 = stride, 3 = region.
- R4: Scores are 16-bit signed with 8 fractional bits. The score of the pair (captured st_prev, previous action) becomes floor((26*Q + 230*T)/256), where T = reward + floor(205*M/256) and M is the largest score in the row of the captured st_cur. The result is limited to the signed 16-bit range.
- R5: Each cycle with dc_hit adds one hit and each cycle with dc_miss adds one miss; both may pulse in the same cycle. On the edge where the access count reaches 256 or more, the reward becomes hits minus misses of that window (one unit of the score format per 256 accesses, so ±256 at the extremes), and the tallies restart at zero.
- R6: A miss accepted at clock edge k holds busy high in the three cycles after edges k, k+1 and k+2. After edge k+3, busy is 0, act_out carries the new action, and act_valid is high for exactly that one cycle. The new action then becomes the previous action.
- R7: A last-level-cache miss sampled while busy is 1 is dropped. It leaves the table and outputs unchanged and increases drop_cnt by one, wrapping at 256.
- R8: An update uses the reward held at edge k+2. A window that completes on that same edge affects only later updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| llc_miss | input | 1 | Last-level-cache miss strobe |
| st_prev | input | 3 | Index of the state before the miss |
| st_cur | input | 3 | Index of the current state |
| dc_hit | input | 1 | DRAM-cache hit pulse |
| dc_miss | input | 1 | DRAM-cache miss pulse |
| act_out | output | 2 | Selected prefetcher |
| act_valid | output | 1 | One-cycle pulse with a new selection |
| busy | output | 1 | Selection/update sequence in progress |
| drop_cnt | output | 8 | Number of misses dropped while busy |

## Verification
Two things can happen on the same edge: a reward window completes, and an update computes its new score. The bench streams long runs of DRAM-cache events, some all hits and some all misses, with both pulses often together. At the same time it fires last-level-cache misses at random intervals, so window boundaries keep landing on compute edges. A behavioural model in the bench follows the same cycle rule (R8) and is compared with the selected actions on every clock. An update that used the new reward too early would bend the learned scores and, within a few requests, the chosen prefetcher.

// File: rtl/qsel_engine.sv
module qsel_engine #(
  parameter int NS_W   = 3,
  parameter int NA_W   = 2,
  parameter int QW     = 16,
  parameter int FRAC   = 8,
  parameter int WIN_W  = 8,
  parameter int ALPHA  = 230,
  parameter int GAMMA  = 205,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              llc_miss,
  input  logic [NS_W-1:0]   st_prev,
  input  logic [NS_W-1:0]   st_cur,
  input  logic              dc_hit,
  input  logic              dc_miss,
  output logic [NA_W-1:0]   act_out,
  output logic              act_valid,
  output logic              busy,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int NA   = 1 << NA_W;
  localparam int NQ   = (1 << NS_W) * NA;
  localparam int ONE  = 1 << FRAC;
  localparam int QMAX = (1 << (QW-1)) - 1;
  localparam int QMIN = -(1 << (QW-1));
  localparam int WIN  = 1 << WIN_W;

  typedef enum logic [1:0] {IDLE, SCAN, CALC, WB} phase_t;
  phase_t phase;

  logic signed [QW-1:0] q [NQ];
  logic [NS_W-1:0]      sp_r, sc_r;
  logic [NA_W-1:0]      a_prev, a_new;
  logic signed [QW-1:0] mx_r, nv_r, reward;
  logic [WIN_W:0]       cnt;
  logic signed [WIN_W+1:0] diff;

  assign busy = (phase != IDLE);

  logic [NA_W-1:0]      best_a;
  logic signed [QW-1:0] best_v, cur_max;
  always_comb begin
    best_a  = '0;
    best_v  = q[{sp_r, {NA_W{1'b0}}}];
    cur_max = q[{sc_r, {NA_W{1'b0}}}];
    for (int a = 1; a < NA; a++) begin
      if (q[{sp_r, NA_W'(a)}] > best_v) begin
        best_v = q[{sp_r, NA_W'(a)}];
        best_a = NA_W'(a);
      end
      if (q[{sc_r, NA_W'(a)}] > cur_max) cur_max = q[{sc_r, NA_W'(a)}];
    end
  end

  logic signed [31:0] mx32, q32, r32, tgt, mix, res;
  logic signed [QW-1:0] res_sat;
  assign mx32 = mx_r;
  assign q32  = q[{sp_r, a_prev}];
  assign r32  = reward;
  assign tgt  = r32 + ((GAMMA * mx32) >>> FRAC);
  assign mix  = ((ONE - ALPHA) * q32) + (ALPHA * tgt);
  assign res  = mix >>> FRAC;
  assign res_sat = (res > QMAX) ? QW'(QMAX) : (res < QMIN) ? QW'(QMIN) : res[QW-1:0];

  logic [31:0]        cnt_n;
  logic signed [31:0] diff_n, rew_n;
  assign cnt_n  = 32'(cnt) + 32'(dc_hit) + 32'(dc_miss);
  assign diff_n = 32'(diff) + $signed(32'(dc_hit)) - $signed(32'(dc_miss));
  assign rew_n  = (diff_n <<< FRAC) >>> WIN_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      diff   <= '0;
      reward <= '0;
    end else if (cnt_n >= WIN) begin
      cnt    <= '0;
      diff   <= '0;
      reward <= rew_n[QW-1:0];
    end else begin
      cnt    <= cnt_n[WIN_W:0];
      diff   <= diff_n[WIN_W+1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      sp_r      <= '0;
      sc_r      <= '0;
      a_prev    <= '0;
      a_new     <= '0;
      mx_r      <= '0;
      nv_r      <= '0;
      act_out   <= '0;
      act_valid <= 1'b0;
      drop_cnt  <= '0;
      for (int i = 0; i < NQ; i++) q[i] <= '0;
    end else begin
      act_valid <= 1'b0;
      if (busy && llc_miss) drop_cnt <= drop_cnt + 1'b1;
      case (phase)
        IDLE: if (llc_miss) begin
          sp_r  <= st_prev;
          sc_r  <= st_cur;
          phase <= SCAN;
        end
        SCAN: begin
          a_new <= best_a;
          mx_r  <= cur_max;
          phase <= CALC;
        end
        CALC: begin
          nv_r  <= res_sat;
          phase <= WB;
        end
        WB: begin
          q[{sp_r, a_prev}] <= nv_r;
          a_prev    <= a_new;
          act_out   <= a_new;
          act_valid <= 1'b1;
          phase     <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qsel_engine_chk.sv
module qsel_engine_chk #(
  parameter int NA_W   = 2,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              llc_miss,
  input logic              busy,
  input logic              act_valid,
  input logic [NA_W-1:0]   act_out,
  input logic [DROP_W-1:0] drop_cnt
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && llc_miss) |=> busy); // R6
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) act_valid |-> (!busy && $past(busy))); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) act_valid |=> !act_valid); // R6
  AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !act_valid |-> $stable(act_out)); // R2
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (busy && llc_miss) |=> (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1))); // R7
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(busy && llc_miss) |=> $stable(drop_cnt)); // R7
endmodule

bind qsel_engine qsel_engine_chk #(.NA_W(NA_W), .DROP_W(DROP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .llc_miss(llc_miss), .busy(busy),
  .act_valid(act_valid), .act_out(act_out), .drop_cnt(drop_cnt)
);

// File: tb/qsel_engine_tb_top.sv
module qsel_engine_tb_top;
  logic clk = 0, rst_n = 0, llc_miss = 0, dc_hit = 0, dc_miss = 0;
  logic [2:0] st_prev = 0, st_cur = 0;
  logic [1:0] act_out;
  logic act_valid, busy;
  logic [7:0] drop_cnt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  qsel_engine dut_i (.clk(clk), .rst_n(rst_n), .llc_miss(llc_miss), .st_prev(st_prev),
    .st_cur(st_cur), .dc_hit(dc_hit), .dc_miss(dc_miss), .act_out(act_out),
    .act_valid(act_valid), .busy(busy), .drop_cnt(drop_cnt));

  int qm [32];
  int ms, sp, sc, ap, an, mx, nv, rew, cnt, dif, drop, act, vld;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (qm[i]) qm[i] = 0;
      ms = 0; sp = 0; sc = 0; ap = 0; an = 0; mx = 0; nv = 0;
      rew = 0; cnt = 0; dif = 0; drop = 0; act = 0; vld = 0;
    end else begin
      vld = 0;
      if (ms != 0 && llc_miss) drop = (drop + 1) % 256;
      case (ms)
        0: if (llc_miss) begin sp = st_prev; sc = st_cur; ms = 1; end
        1: begin
          an = 0; mx = qm[sc*4];
          for (int a = 1; a < 4; a++) begin
            if (qm[sp*4+a] > qm[sp*4+an]) an = a;
            if (qm[sc*4+a] > mx) mx = qm[sc*4+a];
          end
          ms = 2;
        end
        2: begin
          nv = (26*qm[sp*4+ap] + 230*(rew + ((205*mx) >>> 8))) >>> 8;
          if (nv > 32767) nv = 32767;
          if (nv < -32768) nv = -32768;
          ms = 3;
        end
        default: begin
          qm[sp*4+ap] = nv; ap = an; act = an; vld = 1; ms = 0;
        end
      endcase
      cnt = cnt + int'(dc_hit) + int'(dc_miss);
      dif = dif + int'(dc_hit) - int'(dc_miss);
      if (cnt >= 256) begin rew = dif; cnt = 0; dif = 0; end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic step(input bit m, input bit h, input bit d);
    @(negedge clk);
    if (rst_n) begin
      chk("R3 R4 R5 R8 act_out", int'(act_out), act);
      chk("R6 act_valid", int'(act_valid), vld);
      chk("R6 busy", int'(busy), int'(ms != 0));
      chk("R7 drop_cnt", int'(drop_cnt), drop);
    end
    llc_miss = m; dc_hit = h; dc_miss = d;
    st_prev = 3'($urandom_range(0, 7));
    st_cur  = 3'($urandom_range(0, 7));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values at the ports
    chk("R1 act_out", int'(act_out), 0);
    chk("R1 act_valid", int'(act_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 drop_cnt", int'(drop_cnt), 0);
    // R2 R3: zero reward, all ties -> action 0; idle cycles change nothing
    for (int i = 0; i < 200; i++) step($urandom_range(0, 2) == 0, 0, 0);
    repeat (20) step(0, 0, 0);
    chk("R3 tie to lowest", int'(act_out), 0);
    // R5: all-hit windows give positive reward
    for (int i = 0; i < 700; i++) step($urandom_range(0, 5) == 0, 1, 0);
    // R5: all-miss windows give negative reward, pushing choices away
    for (int i = 0; i < 1500; i++) step($urandom_range(0, 4) == 0, 0, 1);
    // R7: back-to-back misses while busy
    for (int i = 0; i < 100; i++) step(1, 1, 1);
    // R8: mixed traffic, window closes landing on compute edges
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 0);
    repeat (8) step(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule